// File: doc/BRIEF.md
# Peripheral Bus Wait-State Generator

This block connects an asynchronous 32-bit CPU bus with dynamic bus sizing to a slow 16-bit network controller that has no ready output. It forms the controller's chip select from one decoded select strobe and turns the transfer size and A0 into the two byte-lane selects. It also withholds the data-transfer acknowledge until the controller's read access time has passed. The wait is measured in periods of a clock that the controller itself supplies. That clock is free-running and has no phase relation to the CPU clock. The CPU bus contributes only level-sensitive strobes.

A 4-bit setting gives the wait length in peripheral clocks, so one implementation serves a slow power-on clock and a fast programmed one. A mode input lets writes be acknowledged without the wait, so that only reads are stretched. After every write the block keeps the controller deselected for a programmed number of peripheral clocks. The bus is expected to leave the select negated for at least three peripheral clocks between read accesses.

Top module: `pbus_wait_gen`

## Requirements
- R1: While rst_n is low with the select negated, pcs_n, bsel_hi_n, bsel_lo_n, dsack1_n, dsack0_n and wait_st are all high.
- R2: Outside a write-recovery window, pcs_n follows sel_n with no clock delay.
- R3: Lane encoding, active low. siz is 2'b01 for a byte, 2'b10 for a word, 2'b11 for three bytes and 2'b00 for a long. bsel_hi_n is active when a0 is 0. bsel_lo_n is active when a0 is 1 or siz is not 2'b01.
- R4: Whenever pcs_n is high, both byte-lane selects are high and dsack1_n is high. This includes a select held off by write recovery.
- R5: For a delayed access with wait_cfg = N (1 to 15), dsack1_n falls on the (N+2)th rising edge of pclk after pcs_n falls: two edges of synchronization, then N counted edges. It is never low combinationally at select.
- R6: With wait_cfg = 0, dsack1_n falls together with pcs_n.
- R7: With fast_wr high, a write (rd_wr_n = 0) is acknowledged together with pcs_n, and reads keep the delay of R5. With fast_wr low, writes are delayed like reads.
- R8: dsack1_n rises with no clock delay when the select is negated. dsack0_n is always high, which signals a 16-bit port.
- R9: wait_st is high exactly while dsack1_n is high.
- R10: After a write, once the end of the access has been seen in the pclk domain, a new select is held off: pcs_n stays high for REC_CLKS further pclk rising edges. Reads start no recovery.
- R11: Once asserted, dsack1_n stays low until the select is negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock output of the peripheral; times the wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Decoded device select from the CPU bus, active low |
| rd_wr_n | input | 1 | Transfer direction, 1 = read |
| siz | input | 2 | Transfer size code |
| a0 | input | 1 | Address bit 0 |
| wait_cfg | input | 4 | Wait length in pclk periods; 0 = no wait |
| fast_wr | input | 1 | 1 = writes skip the wait |
| pcs_n | output | 1 | Chip select to the peripheral, active low |
| bsel_hi_n | output | 1 | Upper byte-lane select, active low |
| bsel_lo_n | output | 1 | Lower byte-lane select, active low |
| dsack1_n | output | 1 | Acknowledge, 16-bit port half |
| dsack0_n | output | 1 | Acknowledge, 8-bit half; held negated |
| wait_st | output | 1 | High while the acknowledge is withheld |

## Verification
The hardest case to reach is a reselect that arrives after the synchronized end of a write but before the recovery window closes. From the ports, this means placing a CPU-side edge between two particular peripheral clock edges. The bench runs the CPU clock at an unrelated, non-commensurate period for the table of accesses, so the select never lands exactly on a pclk edge. For the recovery case it aligns the release and the reselect to known offsets from pclk edges, so that the hold-off and the delayed acknowledge that follows can each be counted to the exact edge.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  localparam logic [1:0] SIZ_BYTE = 2'b01;

  typedef struct packed {
    logic hi;
    logic lo;
  } lanes_t;

  // Active-high lane enables for a 16-bit port on the upper data half.
  function automatic lanes_t lane_map(input logic [1:0] siz, input logic a0);
    lanes_t l;
    l.hi = ~a0;
    l.lo = a0 | (siz != SIZ_BYTE);
    return l;
  endfunction

  // An access skips the counted wait when no wait is set, or when it is
  // a write with the write bypass enabled.
  function automatic logic skip_wait(input logic [3:0] cfg, input logic fast,
                                     input logic rd_wr_n);
    return (cfg == 4'd0) | (fast & ~rd_wr_n);
  endfunction

endpackage

// File: rtl/pwg_sync.sv
module pwg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic pre
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
      assign pre = d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      assign pre = sh[STAGES-2];
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pwg_delay.sv
module pwg_delay #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] cfg,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = cnt + ONE;

  // Up-counter kept cleared while the synchronized select is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!active) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt_next;
      done <= (cnt_next == cfg);
    end
  end

  p_cnt_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0) && !done);

  p_done_at_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg != '0) |-> (cnt == cfg));
endmodule

// File: rtl/pwg_recover.sv
module pwg_recover #(
  parameter int REC_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic pre,
  input  logic rd_wr_n,
  output logic hold
);
  localparam int REC_W = (REC_CLKS > 1) ? $clog2(REC_CLKS) : 1;

  logic             was_wr;
  logic [REC_W-1:0] rcnt;
  logic             end_evt;

  // Synchronized select about to drop at this edge.
  assign end_evt = act & ~pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_wr <= 1'b0;
      hold   <= 1'b0;
      rcnt   <= '0;
    end else begin
      if (act) was_wr <= ~rd_wr_n;
      if (end_evt && was_wr) begin
        hold <= 1'b1;
        rcnt <= REC_W'(REC_CLKS - 1);
      end else if (hold) begin
        if (rcnt == '0) hold <= 1'b0;
        else            rcnt <= rcnt - 1'b1;
      end
    end
  end

  p_hold_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(was_wr));

  p_hold_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && rcnt != '0) |=> hold);
endmodule

// File: rtl/pwg_lanes.sv
module pwg_lanes
  import pwg_pkg::*;
(
  input  logic       sel,
  input  logic [1:0] siz,
  input  logic       a0,
  output logic       hi_n,
  output logic       lo_n
);
  lanes_t en;

  always_comb begin
    en   = lane_map(siz, a0);
    hi_n = ~(sel & en.hi);
    lo_n = ~(sel & en.lo);
  end
endmodule

// File: rtl/pbus_wait_gen.sv
module pbus_wait_gen
  import pwg_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CLKS    = 2
) (
  input  logic             pclk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             rd_wr_n,
  input  logic [1:0]       siz,
  input  logic             a0,
  input  logic [CNT_W-1:0] wait_cfg,
  input  logic             fast_wr,
  output logic             pcs_n,
  output logic             bsel_hi_n,
  output logic             bsel_lo_n,
  output logic             dsack1_n,
  output logic             dsack0_n,
  output logic             wait_st
);
  logic hold;
  logic sel_eff;
  logic sel_sync;
  logic sel_pre;
  logic wait_done;
  logic bypass;
  logic ack;

  assign sel_eff = ~sel_n & ~hold;
  assign pcs_n   = ~sel_eff;

  pwg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(pclk), .rst_n(rst_n), .d(sel_eff), .q(sel_sync), .pre(sel_pre)
  );

  pwg_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(pclk), .rst_n(rst_n), .active(sel_sync), .cfg(wait_cfg),
    .done(wait_done)
  );

  pwg_recover #(.REC_CLKS(REC_CLKS)) u_rec (
    .clk(pclk), .rst_n(rst_n), .act(sel_sync), .pre(sel_pre),
    .rd_wr_n(rd_wr_n), .hold(hold)
  );

  pwg_lanes u_lanes (
    .sel(sel_eff), .siz(siz), .a0(a0), .hi_n(bsel_hi_n), .lo_n(bsel_lo_n)
  );

  assign bypass   = skip_wait(4'(wait_cfg), fast_wr, rd_wr_n);
  assign ack      = sel_eff & (bypass | wait_done);
  assign dsack1_n = ~ack;
  assign dsack0_n = 1'b1;
  assign wait_st  = ~ack;

  p_ack_gated_r8: assert property (@(posedge pclk) disable iff (!rst_n)
    pcs_n |-> dsack1_n);

  p_lane_gate_r4: assert property (@(posedge pclk) disable iff (!rst_n)
    pcs_n |-> (bsel_hi_n && bsel_lo_n));

  p_ack_hold_r11: assert property (@(posedge pclk) disable iff (!rst_n)
    (!dsack1_n && !pcs_n) |=> (pcs_n || !dsack1_n));

  p_hold_blocks_r10: assert property (@(posedge pclk) disable iff (!rst_n)
    hold |-> pcs_n);
endmodule

// File: tb/sim_pbus_wait_gen.sv
`timescale 1ns/1ps
module sim_pbus_wait_gen;
  localparam int SYNC = 2;
  localparam int REC  = 2;
  localparam int NV   = 11;
  // {rd_wr_n, fast_wr, cfg[3:0], siz[1:0], a0, exp_edges[4:0], hi_n, lo_n}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd2,  2'b10, 1'b0, 5'd4,  1'b0, 1'b0},
    {1'b1, 1'b0, 4'd1,  2'b01, 1'b0, 5'd3,  1'b0, 1'b1},
    {1'b1, 1'b0, 4'd3,  2'b01, 1'b1, 5'd5,  1'b1, 1'b0},
    {1'b0, 1'b0, 4'd2,  2'b00, 1'b0, 5'd4,  1'b0, 1'b0},
    {1'b0, 1'b1, 4'd5,  2'b10, 1'b0, 5'd0,  1'b0, 1'b0},
    {1'b1, 1'b1, 4'd5,  2'b11, 1'b1, 5'd7,  1'b1, 1'b0},
    {1'b1, 1'b0, 4'd0,  2'b10, 1'b0, 5'd0,  1'b0, 1'b0},
    {1'b1, 1'b0, 4'd8,  2'b10, 1'b0, 5'd10, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd0,  2'b01, 1'b1, 5'd0,  1'b1, 1'b0},
    {1'b1, 1'b0, 4'd15, 2'b00, 1'b1, 5'd17, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd4,  2'b11, 1'b0, 5'd6,  1'b0, 1'b0}
  };

  logic pclk = 1'b0, cclk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, rd_wr_n = 1'b1, a0 = 1'b0, fast_wr = 1'b0;
  logic [1:0] siz = 2'b10;
  logic [3:0] wait_cfg = 4'd2;
  logic pcs_n, bsel_hi_n, bsel_lo_n, dsack1_n, dsack0_n, wait_st;

  int checks = 0;
  int fails  = 0;

  pbus_wait_gen u0 (
    .pclk(pclk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr_n(rd_wr_n), .siz(siz),
    .a0(a0), .wait_cfg(wait_cfg), .fast_wr(fast_wr), .pcs_n(pcs_n),
    .bsel_hi_n(bsel_hi_n), .bsel_lo_n(bsel_lo_n), .dsack1_n(dsack1_n),
    .dsack0_n(dsack0_n), .wait_st(wait_st)
  );

  always #5 pclk = ~pclk;
  initial begin
    #0.017;
    forever #14.65 cclk = ~cclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_to_ack(output int n);
    n = 0;
    while (dsack1_n && n < 40) begin
      @(posedge pclk);
      n++;
      #1;
      chk(wait_st == dsack1_n, "R9", "wait_st vs dsack1_n", wait_st, dsack1_n);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    #12;
    chk(pcs_n == 1'b1, "R1", "pcs_n in reset", pcs_n, 1);
    chk(bsel_hi_n && bsel_lo_n, "R1", "lanes in reset", {bsel_hi_n, bsel_lo_n}, 3);
    chk(dsack1_n && dsack0_n, "R1", "dsack in reset", {dsack1_n, dsack0_n}, 3);
    chk(wait_st == 1'b1, "R1", "wait_st in reset", wait_st, 1);
    #11 rst_n = 1'b1;
    repeat (3) @(posedge cclk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      int exp_e;
      string rq;
      v = VEC[i];
      exp_e = int'(v[6:2]);
      rq = (exp_e != 0) ? "R5" : ((v[13:10] == 4'd0) ? "R6" : "R7");
      @(posedge cclk);
      rd_wr_n = v[15]; fast_wr = v[14]; wait_cfg = v[13:10];
      siz = v[9:8]; a0 = v[7]; sel_n = 1'b0;
      #0.01;
      chk(pcs_n == 1'b0, "R2", "pcs_n at select", pcs_n, 0);
      chk(bsel_hi_n == v[1], "R3", "bsel_hi_n", bsel_hi_n, v[1]);
      chk(bsel_lo_n == v[0], "R3", "bsel_lo_n", bsel_lo_n, v[0]);
      if (exp_e == 0) begin
        chk(dsack1_n == 1'b0, rq, "immediate ack", dsack1_n, 0);
      end else begin
        chk(dsack1_n == 1'b1, rq, "no ack at select", dsack1_n, 1);
        count_to_ack(n);
        chk(n == exp_e, rq, "edges to ack", n, exp_e);
      end
      chk(dsack0_n == 1'b1, "R8", "dsack0_n", dsack0_n, 1);
      repeat (3) @(posedge pclk);
      #1;
      chk(dsack1_n == 1'b0, "R11", "ack held", dsack1_n, 0);
      @(posedge cclk);
      sel_n = 1'b1;
      #0.01;
      chk(dsack1_n == 1'b1, "R8", "release", dsack1_n, 1);
      chk(wait_st == 1'b1, "R9", "wait_st at release", wait_st, 1);
      chk(bsel_hi_n && bsel_lo_n, "R4", "lanes after release", {bsel_hi_n, bsel_lo_n}, 3);
      repeat (4) @(posedge cclk);
    end

    // Write recovery: reselect after the synchronized end is held off.
    @(posedge pclk); #3;
    rd_wr_n = 1'b0; fast_wr = 1'b0; wait_cfg = 4'd1; siz = 2'b10; a0 = 1'b0;
    sel_n = 1'b0;
    count_to_ack(n);
    chk(n == SYNC + 1, "R5", "write wait cfg 1", n, SYNC + 1);
    repeat (2) @(posedge pclk); #3;
    sel_n = 1'b1;
    repeat (2) @(posedge pclk); #2;
    sel_n = 1'b0;
    #0.5;
    chk(pcs_n == 1'b1, "R10", "pcs_n held after write", pcs_n, 1);
    chk(bsel_hi_n && bsel_lo_n, "R4", "lanes while held", {bsel_hi_n, bsel_lo_n}, 3);
    chk(dsack1_n == 1'b1, "R4", "no ack while held", dsack1_n, 1);
    n = 0;
    while (pcs_n && n < 20) begin
      @(posedge pclk);
      n++;
      #1;
    end
    chk(n == REC, "R10", "edges of hold-off", n, REC);
    chk(bsel_hi_n == 1'b0 && bsel_lo_n == 1'b0, "R3", "lanes after hold", {bsel_hi_n, bsel_lo_n}, 0);
    count_to_ack(n);
    chk(n == SYNC + 1, "R5", "ack after hold", n, SYNC + 1);
    @(posedge pclk); #3;
    sel_n = 1'b1;
    repeat (10) @(posedge pclk);

    // Read: a reselect after the counter has cleared is not held.
    @(posedge pclk); #3;
    rd_wr_n = 1'b1; sel_n = 1'b0;
    count_to_ack(n);
    chk(n == SYNC + 1, "R5", "read wait cfg 1", n, SYNC + 1);
    @(posedge pclk); #3;
    sel_n = 1'b1;
    repeat (3) @(posedge pclk); #2;
    sel_n = 1'b0;
    #0.5;
    chk(pcs_n == 1'b0, "R10", "read starts no hold", pcs_n, 0);
    chk(dsack1_n == 1'b1, "R5", "no stale ack", dsack1_n, 1);
    count_to_ack(n);
    chk(n == SYNC + 1, "R5", "second read wait", n, SYNC + 1);
    @(posedge pclk); #3;
    sel_n = 1'b1;
    #0.5;
    chk(dsack1_n == 1'b1, "R8", "release after read", dsack1_n, 1);
    repeat (5) @(posedge pclk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule